// File: doc/BRIEF.md
# Serial Link Address Translation Unit

This block converts addresses at both ends of a point-to-point, memory-mapped serial link. It has two independent paths.

The outbound path takes an address from the local bus. It discards every bit above bit 25 and subtracts a programmable transmit base. The result is the address that goes into an outgoing request packet.

The inbound path takes the address carried by a received packet and maps it into local space. It uses four programmable windows, and the windows have no base addresses of their own. Window 1 starts at zero. Each later window starts where the one before it ends, so each window's upper limit is the running sum of the window sizes up to and including that window. A matching address gets that window's offset added to it.

Each path uses a valid/ready handshake. The path takes one input, registers the result, and presents it in the next cycle. While that result waits to be taken, the path holds off new input. Each path is a two-state machine, and the states and transitions are named as follows:

- EMPTY: the path holds no result.
- FULL: the path holds a result.
- LOAD (EMPTY to FULL): an input is accepted.
- DRAIN (FULL to EMPTY): the result is taken and no new input arrives.
- REFILL (FULL to FULL): the result is taken and a new input is accepted in the same cycle.
- STALL (FULL to FULL): the result is not taken, and the input is held off.

Software fills the map through a single-cycle register write port.

Top module: `link_addr_xlate`

## Requirements
- R1: After reset, neither path presents a result, both paths are ready, and every map register reads as zero in its effect. In particular, the transmit base is zero and every window has size zero.
- R2: An outbound result equals the input address with bits 31..26 cleared, minus the transmit base.
- R3: An inbound address below the window 1 size is translated by adding the window 1 offset. The error flag is low.
- R4: If the inbound address falls outside window 1, it is tested against windows 2, 3 and 4 in that order. Window k's limit is the sum of sizes 1..k. The first window whose limit exceeds the address is used, and that window's offset is added.
- R5: A window of size zero never matches. It also leaves the limits of the windows after it unchanged.
- R6: An inbound address at or above the sum of all four sizes raises the error flag (ib_out_err = 1), and the result address is zero.
- R7: All additions and subtractions wrap modulo 2^32, with no overflow indication.
- R8: A result appears on the output in the cycle after its input is accepted. While a result is valid and not taken, in_ready is low and the result stays unchanged. When out_ready is high, a new input can be accepted in the same cycle that the current result is taken.
- R9: A register write uses cfg_sel to pick the target: 0 selects the transmit base, 1 to 4 select the size of windows 1 to 4, and 5 to 8 select the offset of windows 1 to 4. Writes to any other cfg_sel value are ignored. A write applies only to inputs accepted after the cycle in which the write is made.
- R10: With a transmit base of 0, a window 1 size of 0x100 and a window 1 offset of 0x0800_0000, inbound address 0x54 yields 0x0800_0054.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Map register write strobe |
| cfg_sel | input | 4 | Map register select |
| cfg_wdata | input | 32 | Map register write value |
| ob_in_valid | input | 1 | Outbound input valid |
| ob_in_ready | output | 1 | Outbound input ready |
| ob_in_addr | input | 32 | Local bus address |
| ob_out_valid | output | 1 | Outbound result valid |
| ob_out_ready | input | 1 | Outbound result taken |
| ob_out_addr | output | 32 | Packet address |
| ib_in_valid | input | 1 | Inbound input valid |
| ib_in_ready | output | 1 | Inbound input ready |
| ib_in_addr | input | 32 | Received packet address |
| ib_out_valid | output | 1 | Inbound result valid |
| ib_out_ready | input | 1 | Inbound result taken |
| ib_out_addr | output | 32 | Local address |
| ib_out_err | output | 1 | No window matched |

## Verification
The bench builds the block with its default parameters: a 32-bit address, 26 kept outbound bits and four windows.

- The full 32-bit width lets offsets and bases near 2^32 exercise wraparound on both paths.
- The 26-bit cut lets inputs with the upper bits set show that the truncation happens before the subtraction.
- Four windows give room for a zero-size window between two live ones, and for addresses placed exactly on each running limit.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } stage_state_e;

endpackage

// File: rtl/xlate_regs.sv
module xlate_regs #(
    parameter int ADDR_W  = 32,
    parameter int NUM_REG = 4,
    parameter int SEL_W   = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             we_i,
    input  logic [SEL_W-1:0]                 sel_i,
    input  logic [ADDR_W-1:0]                wdata_i,
    output logic [ADDR_W-1:0]                tx_base_o,
    output logic [NUM_REG-1:0][ADDR_W-1:0]   size_o,
    output logic [NUM_REG-1:0][ADDR_W-1:0]   off_o
);

    localparam int SIZE_SEL0 = 1;
    localparam int OFF_SEL0  = 1 + NUM_REG;

    logic [ADDR_W-1:0] base_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (we_i && (sel_i == SEL_W'(0))) begin
            base_q <= wdata_i;
        end
    end

    assign tx_base_o = base_q;

    for (genvar k = 0; k < NUM_REG; k++) begin : g_win
        logic [ADDR_W-1:0] sz_q;
        logic [ADDR_W-1:0] of_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sz_q <= '0;
                of_q <= '0;
            end else if (we_i) begin
                if (sel_i == SEL_W'(SIZE_SEL0 + k)) sz_q <= wdata_i;
                if (sel_i == SEL_W'(OFF_SEL0 + k))  of_q <= wdata_i;
            end
        end

        assign size_o[k] = sz_q;
        assign off_o[k]  = of_q;
    end

endmodule

// File: rtl/ob_map.sv
module ob_map #(
    parameter int ADDR_W = 32,
    parameter int KEEP_W = 26
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ADDR_W-1:0] base_i,
    output logic [ADDR_W-1:0] addr_o
);

    logic [ADDR_W-1:0] kept;

    if (KEEP_W < ADDR_W) begin : g_cut
        assign kept = {{(ADDR_W-KEEP_W){1'b0}}, addr_i[KEEP_W-1:0]};
    end else begin : g_full
        assign kept = addr_i;
    end

    assign addr_o = kept - base_i;

endmodule

// File: rtl/ib_map.sv
module ib_map #(
    parameter int ADDR_W  = 32,
    parameter int NUM_REG = 4
) (
    input  logic [ADDR_W-1:0]               addr_i,
    input  logic [NUM_REG-1:0][ADDR_W-1:0]  size_i,
    input  logic [NUM_REG-1:0][ADDR_W-1:0]  off_i,
    output logic [ADDR_W-1:0]               addr_o,
    output logic                            err_o
);

    logic [NUM_REG-1:0] hit;
    logic [ADDR_W-1:0]  run;

    // running limit: window k ends at size_1 + ... + size_k
    always_comb begin
        run = '0;
        hit = '0;
        for (int k = 0; k < NUM_REG; k++) begin
            run    = run + size_i[k];
            hit[k] = (size_i[k] != '0) && (addr_i < run);
        end
    end

    // lowest numbered hit wins: scan from the top so it is written last
    always_comb begin
        err_o  = 1'b1;
        addr_o = '0;
        for (int k = NUM_REG - 1; k >= 0; k--) begin
            if (hit[k]) begin
                err_o  = 1'b0;
                addr_o = addr_i + off_i[k];
            end
        end
    end

endmodule

// File: rtl/xlate_stage.sv
module xlate_stage
    import xlate_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data
);

    stage_state_e state_q, state_d;
    logic [DATA_W-1:0] data_q;
    logic accept;

    assign in_ready  = (state_q == ST_EMPTY) || out_ready;
    assign accept    = in_valid && in_ready;
    assign out_valid = (state_q == ST_FULL);
    assign out_data  = data_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (in_valid) state_d = ST_FULL;                  // LOAD
            ST_FULL:  if (out_ready && !in_valid) state_d = ST_EMPTY;   // DRAIN; else REFILL or STALL
            default:  state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      data_q <= '0;
        else if (accept) data_q <= in_data;
    end

    AST_RESULT_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);                            // R8
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));   // R8
    AST_NO_ACCEPT_WHEN_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);                         // R8
    AST_DRAIN_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !in_valid) |=> !out_valid);            // R8

endmodule

// File: rtl/link_addr_xlate.sv
module link_addr_xlate
    import xlate_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int KEEP_W  = 26,
    parameter int NUM_REG = 4,
    localparam int SEL_W  = $clog2(2 * NUM_REG + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              ob_in_valid,
    output logic              ob_in_ready,
    input  logic [ADDR_W-1:0] ob_in_addr,
    output logic              ob_out_valid,
    input  logic              ob_out_ready,
    output logic [ADDR_W-1:0] ob_out_addr,
    input  logic              ib_in_valid,
    output logic              ib_in_ready,
    input  logic [ADDR_W-1:0] ib_in_addr,
    output logic              ib_out_valid,
    input  logic              ib_out_ready,
    output logic [ADDR_W-1:0] ib_out_addr,
    output logic              ib_out_err
);

    logic [ADDR_W-1:0]              tx_base;
    logic [NUM_REG-1:0][ADDR_W-1:0] win_size;
    logic [NUM_REG-1:0][ADDR_W-1:0] win_off;
    logic [ADDR_W-1:0]              ob_xlat;
    logic [ADDR_W-1:0]              ib_xlat;
    logic                           ib_miss;
    logic [ADDR_W:0]                ib_res;

    xlate_regs #(.ADDR_W(ADDR_W), .NUM_REG(NUM_REG), .SEL_W(SEL_W)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (cfg_we),
        .sel_i     (cfg_sel),
        .wdata_i   (cfg_wdata),
        .tx_base_o (tx_base),
        .size_o    (win_size),
        .off_o     (win_off)
    );

    ob_map #(.ADDR_W(ADDR_W), .KEEP_W(KEEP_W)) i_ob_map (
        .addr_i (ob_in_addr),
        .base_i (tx_base),
        .addr_o (ob_xlat)
    );

    ib_map #(.ADDR_W(ADDR_W), .NUM_REG(NUM_REG)) i_ib_map (
        .addr_i (ib_in_addr),
        .size_i (win_size),
        .off_i  (win_off),
        .addr_o (ib_xlat),
        .err_o  (ib_miss)
    );

    xlate_stage #(.DATA_W(ADDR_W)) i_ob_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (ob_in_valid),
        .in_ready  (ob_in_ready),
        .in_data   (ob_xlat),
        .out_valid (ob_out_valid),
        .out_ready (ob_out_ready),
        .out_data  (ob_out_addr)
    );

    xlate_stage #(.DATA_W(ADDR_W + 1)) i_ib_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (ib_in_valid),
        .in_ready  (ib_in_ready),
        .in_data   ({ib_miss, ib_xlat}),
        .out_valid (ib_out_valid),
        .out_ready (ib_out_ready),
        .out_data  (ib_res)
    );

    assign ib_out_err  = ib_res[ADDR_W];
    assign ib_out_addr = ib_res[ADDR_W-1:0];

    AST_MISS_GIVES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ib_out_valid && ib_out_err) |-> (ib_out_addr == '0));                 // R6
    AST_OB_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !ob_out_valid |-> ob_in_ready);                                        // R8
    AST_IB_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !ib_out_valid |-> ib_in_ready);                                        // R8

endmodule

// File: tb/test_link_addr_xlate.sv
module test_link_addr_xlate;

    localparam longint unsigned MASK32 = 64'hFFFF_FFFF;
    localparam longint unsigned MASK26 = 64'h03FF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        ob_in_valid = 1'b0, ob_out_ready = 1'b1;
    logic [31:0] ob_in_addr = '0;
    logic        ib_in_valid = 1'b0, ib_out_ready = 1'b1;
    logic [31:0] ib_in_addr = '0;
    logic        ob_in_ready, ob_out_valid, ib_in_ready, ib_out_valid, ib_out_err;
    logic [31:0] ob_out_addr, ib_out_addr;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    link_addr_xlate i_link_addr_xlate (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .ob_in_valid(ob_in_valid), .ob_in_ready(ob_in_ready), .ob_in_addr(ob_in_addr),
        .ob_out_valid(ob_out_valid), .ob_out_ready(ob_out_ready), .ob_out_addr(ob_out_addr),
        .ib_in_valid(ib_in_valid), .ib_in_ready(ib_in_ready), .ib_in_addr(ib_in_addr),
        .ib_out_valid(ib_out_valid), .ib_out_ready(ib_out_ready), .ib_out_addr(ib_out_addr),
        .ib_out_err(ib_out_err)
    );

    // behavioural reference model
    longint unsigned m_base;
    longint unsigned m_size[4];
    longint unsigned m_off[4];
    bit              m_ob_v, m_ib_v, m_ib_e;
    longint unsigned m_ob_a, m_ib_a;

    function automatic void ref_ib(input longint unsigned a, output longint unsigned r, output bit e);
        longint unsigned lim = 0;
        e = 1'b1;
        r = 0;
        for (int k = 0; k < 4; k++) begin
            lim = (lim + m_size[k]) & MASK32;
            if (e && m_size[k] != 0 && a < lim) begin
                r = (a + m_off[k]) & MASK32;
                e = 1'b0;
            end
        end
    endfunction

    task automatic chk(input string what, input longint unsigned act, input longint unsigned exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h at t=%0t", cur_req, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        bit acc;
        longint unsigned r;
        bit e;
        cycles++;
        if (!rst_n) begin
            m_base = 0;
            for (int k = 0; k < 4; k++) begin m_size[k] = 0; m_off[k] = 0; end
            m_ob_v = 0; m_ib_v = 0; m_ib_e = 0; m_ob_a = 0; m_ib_a = 0;
        end else begin
            acc = ob_in_valid && (!m_ob_v || ob_out_ready);
            if (acc) begin
                m_ob_v = 1;
                m_ob_a = ((longint'(ob_in_addr) & MASK26) - m_base) & MASK32;
            end else if (ob_out_ready) m_ob_v = 0;
            acc = ib_in_valid && (!m_ib_v || ib_out_ready);
            if (acc) begin
                ref_ib(longint'(ib_in_addr), r, e);
                m_ib_v = 1; m_ib_a = r; m_ib_e = e;
            end else if (ib_out_ready) m_ib_v = 0;
            if (cfg_we) begin
                if (cfg_sel == 0) m_base = cfg_wdata;
                else if (cfg_sel <= 4) m_size[cfg_sel - 1] = cfg_wdata;
                else if (cfg_sel <= 8) m_off[cfg_sel - 5] = cfg_wdata;
            end
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (!rst_n) begin
            chk("R1 reset ob_out_valid", ob_out_valid, 0);
            chk("R1 reset ib_out_valid", ib_out_valid, 0);
        end else begin
            chk("ob_out_valid", ob_out_valid, m_ob_v);
            chk("ib_out_valid", ib_out_valid, m_ib_v);
            chk("R8 ob_in_ready", ob_in_ready, !m_ob_v || ob_out_ready);
            chk("R8 ib_in_ready", ib_in_ready, !m_ib_v || ib_out_ready);
            if (m_ob_v) chk("ob_out_addr", ob_out_addr, m_ob_a);
            if (m_ib_v) begin
                chk("ib_out_addr", ib_out_addr, m_ib_a);
                chk("ib_out_err", ib_out_err, m_ib_e);
            end
        end
    end

    task automatic wr(input int sel, input longint unsigned val);
        @(posedge clk); #1;
        cfg_we = 1; cfg_sel = 4'(sel); cfg_wdata = 32'(val);
        @(posedge clk); #1;
        cfg_we = 0;
    endtask

    task automatic send_ob(input longint unsigned a);
        @(posedge clk); #1;
        ob_in_valid = 1; ob_in_addr = 32'(a);
        forever begin
            @(negedge clk);
            if (ob_in_ready) break;
        end
        @(posedge clk); #1;
        ob_in_valid = 0;
    endtask

    task automatic send_ib(input longint unsigned a);
        @(posedge clk); #1;
        ib_in_valid = 1; ib_in_addr = 32'(a);
        forever begin
            @(negedge clk);
            if (ib_in_ready) break;
        end
        @(posedge clk); #1;
        ib_in_valid = 0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            if (cycles > 50000) begin
                checks++; errors++;
                $display("FAIL watchdog: actual=%0d expected<=50000 cycles", cycles);
                finish_run();
            end
        end
    end

    initial begin
        cur_req = "R1";
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // all sizes zero after reset, so any inbound address misses
        send_ib(0);
        repeat (2) @(posedge clk);

        cur_req = "R10";
        wr(1, 64'h100);
        wr(5, 64'h0800_0000);
        send_ib(64'h54);
        @(negedge clk);
        chk("R10 literal ib_out_addr", ib_out_addr, 64'h0800_0054);
        chk("R10 literal ib_out_err", ib_out_err, 0);

        cur_req = "R3";
        send_ib(64'h0);
        send_ib(64'hFF);

        cur_req = "R2";
        wr(0, 64'h1000);
        send_ob(64'hFC00_2345);
        send_ob(64'h03FF_FFFF);
        send_ob(64'h0000_1000);

        cur_req = "R7";
        send_ob(64'h0000_0010);
        wr(5, 64'hFFFF_FF00);
        send_ib(64'hF0);

        cur_req = "R4";
        wr(2, 64'h200); wr(3, 64'h400); wr(4, 64'h800);
        wr(5, 64'h1000_0000); wr(6, 64'h2000_0000); wr(7, 64'h3000_0000); wr(8, 64'h4000_0000);
        send_ib(64'hFF); send_ib(64'h100); send_ib(64'h2FF); send_ib(64'h300);
        send_ib(64'h6FF); send_ib(64'h700); send_ib(64'hEFF);

        cur_req = "R6";
        send_ib(64'hF00); send_ib(64'hFFFF_FFFF);

        cur_req = "R5";
        wr(2, 64'h0);
        send_ib(64'h100); send_ib(64'h4FF); send_ib(64'h500); send_ib(64'hCFF); send_ib(64'hD00);
        wr(1, 64'h0);
        send_ib(64'h0); send_ib(64'h3FF);

        cur_req = "R9";
        wr(12, 64'h5555_5555);
        wr(15, 64'h0);
        send_ib(64'h10); send_ob(64'h2000);
        @(posedge clk); #1;
        cfg_we = 1; cfg_sel = 4'd3; cfg_wdata = 32'h0;
        ib_in_valid = 1; ib_in_addr = 32'h10;
        @(posedge clk); #1;
        cfg_we = 0; ib_in_addr = 32'h11;
        @(posedge clk); #1;
        ib_in_valid = 0;
        repeat (2) @(posedge clk);

        cur_req = "R8";
        wr(1, 64'h1_0000); wr(5, 64'h0);
        @(posedge clk); #1;
        ob_out_ready = 0; ib_out_ready = 0;
        ob_in_valid = 1; ob_in_addr = 32'h0000_3000;
        ib_in_valid = 1; ib_in_addr = 32'h20;
        @(posedge clk); #1;
        ob_in_addr = 32'h0000_4000; ib_in_addr = 32'h30;
        repeat (4) @(posedge clk);
        #1 ob_out_ready = 1; ib_out_ready = 1;
        @(posedge clk); #1;
        ob_in_addr = 32'h0000_5000; ib_in_addr = 32'h40;
        @(posedge clk); #1;
        ob_in_valid = 0; ib_in_valid = 0;
        for (int i = 0; i < 40; i++) begin
            @(posedge clk); #1;
            ob_out_ready = (i % 3) != 1;
            ib_out_ready = (i % 4) != 2;
            ob_in_valid = (i % 5) != 0;
            ib_in_valid = (i % 2) == 0;
            ob_in_addr = 32'(i * 32'h0111_1111);
            ib_in_addr = 32'(i * 32'h0000_0931);
        end
        @(posedge clk); #1;
        ob_in_valid = 0; ib_in_valid = 0; ob_out_ready = 1; ib_out_ready = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        finish_run();
    end

endmodule